// File: doc/BRIEF.md
# Bus Clock Strobe Prescaler Tree

This block turns one free-running system clock into a set of single-cycle clock-enable strobes, one for each derived clock domain. Logic in a derived domain stays on the system clock and advances only in cycles where its strobe is high. The high-speed bus strobe divides the system clock. Two peripheral bus strobes divide the high-speed bus strobe. A converter strobe divides the second peripheral bus strobe. A sigma-delta converter strobe divides the system clock directly.

Each divider is set by a small encoded field. Every divider counts the strobes of its parent domain. It loads a new setting only when its count wraps at the end of an output period, so a change never shortens the period already running. Field codes that map to no divisor fall back to the nearest smaller legal divisor. Until the first wrap after reset, the bus and peripheral dividers run at /1 and the converter and sigma-delta dividers run at /2.

Top module: `bclk_tree`

## Requirements
- R1: `hb_sel` codes 0..8 give `hb_en` periods of 1, 2, 4, 8, 16, 64, 128, 256 and 512 system clock cycles. There is no /32 setting.
- R2: `hb_sel` codes 9..15 are unused and behave as /512.
- R3: `pb1_sel` and `pb2_sel` codes 0..4 give a peripheral strobe on every 1st, 2nd, 4th, 8th or 16th `hb_en` strobe. The unused codes 5..7 behave as /16.
- R4: `cv_sel` codes 0, 1, 2 and 3 give a `cv_en` strobe on every 2nd, 4th, 6th or 8th `pb2_en` strobe.
- R5: `sd_sel` code c gives an `sd_en` period of 2*(c+1) system cycles for c in 0..7, and 4*(c-3) system cycles for c in 8..15. The resulting divisors are 2 to 16 in steps of 2, then 20 to 48 in steps of 4.
- R6: The strobes are nested. `pb1_en` and `pb2_en` are high only in cycles where `hb_en` is high, and `cv_en` is high only in cycles where `pb2_en` is high.
- R7: A /1 setting holds the strobe high in every cycle in which its parent strobe is high.
- R8: While `rst_n` is low, every strobe is low. In the first cycle after release, `hb_en` is high because the bus divider starts at /1. The field value present at that point is loaded at that first wrap.
- R9: A setting change is loaded only when the count wraps. The output period in progress when the change happens keeps its old length, and the new period starts after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hb_sel | input | 4 | High-speed bus divider code |
| pb1_sel | input | 3 | First peripheral bus divider code |
| pb2_sel | input | 3 | Second peripheral bus divider code |
| cv_sel | input | 2 | Converter divider code (relative to the second peripheral bus) |
| sd_sel | input | 4 | Sigma-delta converter divider code |
| hb_en | output | 1 | High-speed bus clock-enable strobe |
| pb1_en | output | 1 | First peripheral bus clock-enable strobe |
| pb2_en | output | 1 | Second peripheral bus clock-enable strobe |
| cv_en | output | 1 | Converter clock-enable strobe |
| sd_en | output | 1 | Sigma-delta converter clock-enable strobe |

## Verification
The bench sweeps every code of every field and measures the distance between strobes in system cycles. This catches a bus divider that keeps a /32 step and so shifts every higher code by one octave. It also catches unused codes that wrap to small divisors instead of saturating, and a sigma-delta decoder that keeps stepping by 2 past /16.

A setting is changed in the middle of a long period to expose a divider that reloads at once and cuts the running period short. A monitor checks for the whole run that no child strobe appears outside its parent strobe; a free-running child counter would break this nesting. The reset release is checked for strobes that leak during reset and for a bus divider that does not start at /1.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  // field widths
  parameter int HB_SEL_W = 4;
  parameter int PB_SEL_W = 3;
  parameter int CV_SEL_W = 2;
  parameter int SD_SEL_W = 4;
  // largest divisors
  parameter int HB_MAX_DIV = 512;
  parameter int PB_MAX_DIV = 16;
  parameter int CV_MAX_DIV = 8;
  parameter int SD_MAX_DIV = 48;
  // terminal-count widths (terminal = divisor - 1)
  localparam int HB_TW = $clog2(HB_MAX_DIV);
  localparam int PB_TW = $clog2(PB_MAX_DIV);
  localparam int CV_TW = $clog2(CV_MAX_DIV);
  localparam int SD_TW = $clog2(SD_MAX_DIV);
  localparam int NUM_PB = 2;

  // Bus divider: powers of two with the /32 step missing; codes past /512 saturate
  function automatic logic [HB_TW-1:0] hb_term(input logic [HB_SEL_W-1:0] code);
    int d;
    if (code <= 4)      d = 1 << code;
    else if (code <= 8) d = 1 << (code + 1);
    else                d = HB_MAX_DIV;
    return HB_TW'(d - 1);
  endfunction

  // Peripheral bus divider: /1../16, unused codes saturate at /16
  function automatic logic [PB_TW-1:0] pb_term(input logic [PB_SEL_W-1:0] code);
    int d;
    if (code <= 4) d = 1 << code;
    else           d = PB_MAX_DIV;
    return PB_TW'(d - 1);
  endfunction

  // Converter divider: even divisors 2..8
  function automatic logic [CV_TW-1:0] cv_term(input logic [CV_SEL_W-1:0] code);
    int d;
    d = 2 * (int'(code) + 1);
    return CV_TW'(d - 1);
  endfunction

  // Sigma-delta divider: steps of 2 up to 16, then steps of 4 up to 48
  function automatic logic [SD_TW-1:0] sd_term(input logic [SD_SEL_W-1:0] code);
    int d;
    if (code <= 7) d = 2 * (int'(code) + 1);
    else           d = 4 * (int'(code) - 3);
    return SD_TW'(d - 1);
  endfunction
endpackage

// File: rtl/bclk_decode.sv
module bclk_decode
  import bclk_pkg::*;
(
  input  logic [HB_SEL_W-1:0] hb_sel_i,
  input  logic [PB_SEL_W-1:0] pb_sel_i [NUM_PB],
  input  logic [CV_SEL_W-1:0] cv_sel_i,
  input  logic [SD_SEL_W-1:0] sd_sel_i,
  output logic [HB_TW-1:0]    hb_term_o,
  output logic [PB_TW-1:0]    pb_term_o [NUM_PB],
  output logic [CV_TW-1:0]    cv_term_o,
  output logic [SD_TW-1:0]    sd_term_o
);
  always_comb begin
    hb_term_o = hb_term(hb_sel_i);
    cv_term_o = cv_term(cv_sel_i);
    sd_term_o = sd_term(sd_sel_i);
  end

  for (genvar g = 0; g < NUM_PB; g++) begin : g_pb_dec
    always_comb pb_term_o[g] = pb_term(pb_sel_i[g]);
  end
endmodule

// File: rtl/bclk_div_core.sv
module bclk_div_core #(
  parameter int TW       = 4,
  parameter int RST_TERM = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [TW-1:0] term_i,
  output logic          strobe_o
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] term_q, term_d;
  logic          wrap;

  // next state: count parent ticks, reload the setting only on wrap
  always_comb begin
    wrap   = tick_i && (cnt_q == term_q);
    cnt_d  = cnt_q;
    term_d = term_q;
    if (wrap) begin
      cnt_d  = '0;
      term_d = term_i;
    end else if (tick_i) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= TW'(RST_TERM);
    end else begin
      cnt_q  <= cnt_d;
      term_q <= term_d;
    end
  end

  assign strobe_o = wrap;

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_q);
  assert_hold_setting_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |=> $stable(term_q));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> cnt_q == '0);
endmodule

// File: rtl/bclk_tree.sv
module bclk_tree
  import bclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HB_SEL_W-1:0] hb_sel,
  input  logic [PB_SEL_W-1:0] pb1_sel,
  input  logic [PB_SEL_W-1:0] pb2_sel,
  input  logic [CV_SEL_W-1:0] cv_sel,
  input  logic [SD_SEL_W-1:0] sd_sel,
  output logic                hb_en,
  output logic                pb1_en,
  output logic                pb2_en,
  output logic                cv_en,
  output logic                sd_en
);
  logic              run_q;
  logic [PB_SEL_W-1:0] pb_sel [NUM_PB];
  logic [HB_TW-1:0]  hb_term_w;
  logic [PB_TW-1:0]  pb_term_w [NUM_PB];
  logic [CV_TW-1:0]  cv_term_w;
  logic [SD_TW-1:0]  sd_term_w;
  logic [NUM_PB-1:0] pb_en_w;

  // system-domain enable: low in reset, high from the first cycle after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign pb_sel[0] = pb1_sel;
  assign pb_sel[1] = pb2_sel;

  bclk_decode u_dec (
    .hb_sel_i (hb_sel),
    .pb_sel_i (pb_sel),
    .cv_sel_i (cv_sel),
    .sd_sel_i (sd_sel),
    .hb_term_o(hb_term_w),
    .pb_term_o(pb_term_w),
    .cv_term_o(cv_term_w),
    .sd_term_o(sd_term_w)
  );

  bclk_div_core #(.TW(HB_TW), .RST_TERM(0)) u_hb (
    .clk(clk), .rst_n(rst_n), .tick_i(run_q), .term_i(hb_term_w), .strobe_o(hb_en)
  );

  for (genvar g = 0; g < NUM_PB; g++) begin : g_pb
    bclk_div_core #(.TW(PB_TW), .RST_TERM(0)) u_pb (
      .clk(clk), .rst_n(rst_n), .tick_i(hb_en), .term_i(pb_term_w[g]),
      .strobe_o(pb_en_w[g])
    );
  end

  assign pb1_en = pb_en_w[0];
  assign pb2_en = pb_en_w[1];

  bclk_div_core #(.TW(CV_TW), .RST_TERM(1)) u_cv (
    .clk(clk), .rst_n(rst_n), .tick_i(pb2_en), .term_i(cv_term_w), .strobe_o(cv_en)
  );

  bclk_div_core #(.TW(SD_TW), .RST_TERM(1)) u_sd (
    .clk(clk), .rst_n(rst_n), .tick_i(run_q), .term_i(sd_term_w), .strobe_o(sd_en)
  );

  assert_hb_pow2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({1'b0, hb_term_w} + (HB_TW+1)'(1)));
  assert_hb_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_sel > 8) |-> (hb_term_w == HB_TW'(HB_MAX_DIV - 1)));
  assert_pb1_nested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pb1_en |-> hb_en);
  assert_pb2_nested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pb2_en |-> hb_en);
  assert_cv_nested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cv_en |-> pb2_en);
  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n |-> !(hb_en || pb1_en || pb2_en || cv_en || sd_en));
endmodule

// File: tb/bclk_tree_bench.sv
module bclk_tree_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hb_sel = '0;
  logic [2:0] pb1_sel = '0;
  logic [2:0] pb2_sel = '0;
  logic [1:0] cv_sel = '0;
  logic [3:0] sd_sel = '0;
  logic hb_en, pb1_en, pb2_en, cv_en, sd_en;
  int checks = 0;
  int failures = 0;
  int nest_viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bclk_tree u_bclk_tree (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .pb1_sel(pb1_sel), .pb2_sel(pb2_sel),
    .cv_sel(cv_sel), .sd_sel(sd_sel), .hb_en(hb_en), .pb1_en(pb1_en),
    .pb2_en(pb2_en), .cv_en(cv_en), .sd_en(sd_en)
  );

  // expected divisors, from the requirements
  function automatic int exp_hb(int c);
    if (c <= 4) return 1 << c;
    if (c <= 8) return 1 << (c + 1);
    return 512;
  endfunction
  function automatic int exp_pb(int c);
    return (c <= 4) ? (1 << c) : 16;
  endfunction
  function automatic int exp_sd(int c);
    return (c <= 7) ? 2 * (c + 1) : 4 * (c - 3);
  endfunction

  function automatic logic pick(int i);
    case (i)
      0: return hb_en;
      1: return pb1_en;
      2: return pb2_en;
      3: return cv_en;
      default: return sd_en;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe(int i);
    do @(negedge clk); while (!pick(i));
  endtask

  // cycles from the current strobe to the next one
  task automatic measure(int i, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!pick(i));
  endtask

  // apply the new setting, let it load at a wrap, then measure
  task automatic period_of(int i, output int n);
    wait_strobe(i);
    wait_strobe(i);
    measure(i, n);
  endtask

  always @(negedge clk) if (rst_n) begin
    if ((pb1_en && !hb_en) || (pb2_en && !hb_en) || (cv_en && !pb2_en)) nest_viol++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    bit all_hi;
    hb_sel = 4'd3;
    repeat (3) @(negedge clk);
    // R8: quiet during reset
    chk(!(hb_en | pb1_en | pb2_en | cv_en | sd_en), "R8 reset quiet",
        {hb_en, pb1_en, pb2_en, cv_en, sd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hb_en == 1'b1, "R8 first hb strobe after release", hb_en, 1);
    measure(0, n);
    chk(n == 8, "R8 loaded setting after first wrap", n, 8);

    // R1/R2: bus divider sweep
    for (int c = 0; c < 16; c++) begin
      hb_sel = 4'(c);
      period_of(0, n);
      chk(n == exp_hb(c), (c <= 8) ? "R1 hb period" : "R2 hb unused code", n, exp_hb(c));
    end

    // R3: peripheral dividers under hb /2
    hb_sel = 4'd1;
    for (int c = 0; c < 8; c++) begin
      pb1_sel = 3'(c);
      pb2_sel = 3'(7 - c);
      period_of(1, n);
      chk(n == 2 * exp_pb(c), "R3 pb1 period", n, 2 * exp_pb(c));
      period_of(2, n);
      chk(n == 2 * exp_pb(7 - c), "R3 pb2 period", n, 2 * exp_pb(7 - c));
    end

    // R4: converter under hb /2, pb2 /2
    pb2_sel = 3'd1;
    for (int c = 0; c < 4; c++) begin
      cv_sel = 2'(c);
      period_of(3, n);
      chk(n == 4 * 2 * (c + 1), "R4 cv period", n, 8 * (c + 1));
    end

    // R5: sigma-delta sweep
    for (int c = 0; c < 16; c++) begin
      sd_sel = 4'(c);
      period_of(4, n);
      chk(n == exp_sd(c), "R5 sd period", n, exp_sd(c));
    end

    // R7: /1 holds strobe high with its parent
    hb_sel = 4'd0;
    wait_strobe(0); wait_strobe(0);
    all_hi = 1'b1;
    for (int k = 0; k < 20; k++) begin @(negedge clk); all_hi &= hb_en; end
    chk(all_hi, "R7 hb /1 always high", all_hi, 1);
    hb_sel = 4'd2; pb1_sel = 3'd0;
    wait_strobe(0); wait_strobe(0); wait_strobe(1);
    all_hi = 1'b1;
    for (int k = 0; k < 40; k++) begin @(negedge clk); all_hi &= (pb1_en == hb_en); end
    chk(all_hi, "R7 pb1 /1 follows hb", all_hi, 1);

    // R9: change mid-period does not shorten the running period
    sd_sel = 4'd15;
    wait_strobe(4); wait_strobe(4);
    repeat (5) @(negedge clk);
    sd_sel = 4'd0;
    measure(4, n);
    chk(n + 5 == 48, "R9 running period kept", n + 5, 48);
    measure(4, n);
    chk(n == 2, "R9 new period after wrap", n, 2);

    // R6: nesting held across the whole run and a mixed setting
    hb_sel = 4'd1; pb1_sel = 3'd2; pb2_sel = 3'd1; cv_sel = 2'd2;
    repeat (300) @(negedge clk);
    chk(nest_viol == 0, "R6 strobe nesting", nest_viol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule